// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the word address for a synchronous burst memory. On a cycle where either of two load strobes is high, it takes the external address. On later cycles, each cycle with the step input high moves the two low address bits to the next of four beats. The upper bits stay as they were loaded. A step never carries out of the aligned four-word block.

A mode input selects the beat ordering. With the mode high (the default), the ordering is interleaved: the low bits on beat k are the starting low bits XOR k. With the mode low, the ordering is linear: the low bits count up modulo four from the starting value. The block also reports a beat index from 0 to 3, counted from the last load. A new address can be loaded on every cycle, so bursting is optional.

Top module: `burst_addr_gen`

## Requirements
- R1: While rstN is low, the registers clear. After reset, addrOut is 0 and beatIdx is 0.
- R2: When primLoad or auxLoad is high at a rising edge, addrOut becomes addrIn and beatIdx becomes 0 after that edge. This holds for each strobe alone.
- R3: A load takes priority over step in the same cycle.
- R4: When no load strobe is high and step is high, beatIdx increments modulo 4.
- R5: With orderSel=1 (interleaved), the low two bits of addrOut equal the start low bits XOR beatIdx.
- R6: With orderSel=0 (linear), the low two bits of addrOut equal (start low bits + beatIdx) mod 4, wrapping from 3 to 0.
- R7: Bits above bit 1 of addrOut never change except on a load. The low bits never carry into them.
- R8: When no load strobe and no step is high, addrOut and beatIdx hold their values.
- R9: Loads on back-to-back cycles each take effect with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | External start address |
| primLoad | input | 1 | First load strobe |
| auxLoad | input | 1 | Second load strobe |
| step | input | 1 | Advance to the next beat |
| orderSel | input | 1 | 1 = interleaved, 0 = linear |
| addrOut | output | ADDR_W | Current burst address |
| beatIdx | output | 2 | Beat position since the last load |

## Verification
The bench starts bursts from every low-bit value in both orderings. A design that used plain addition in interleaved mode, or XOR in linear mode, would produce the wrong second and fourth beats there. A start address ending in 3 in linear mode exposes a design that carries into the upper bits: its addrOut would leave the aligned block. Other cases cover a load and a step in the same cycle, idle cycles, and loads on consecutive cycles. A design with the wrong priority would advance instead of reloading, and a design that ignored one strobe would keep a stale address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;
    logic advance;
  } burstCtrl_t;

  function automatic logic [BEAT_W-1:0] nextLow(
    input logic [BEAT_W-1:0] startLow,
    input logic [BEAT_W-1:0] beat,
    input logic interleave);
    if (interleave) return startLow ^ beat;
    return startLow + beat;
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic primLoad,
  input  logic auxLoad,
  input  logic step,
  output burstCtrl_t ctrl,
  output logic [BEAT_W-1:0] beatIdx
);
  logic [BEAT_W-1:0] beatQ;

  always_comb begin
    ctrl.load    = primLoad | auxLoad;
    ctrl.advance = step & ~(primLoad | auxLoad);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             beatQ <= '0;
    else if (ctrl.load)    beatQ <= '0;
    else if (ctrl.advance) beatQ <= beatQ + 1'b1;
  end

  assign beatIdx = beatQ;

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (primLoad | auxLoad) |=> beatQ == '0);

  a_r4_step_inc: assert property (@(posedge clk) disable iff (!rstN)
    (!primLoad && !auxLoad && step) |=> beatQ == $past(beatQ) + 2'd1);

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!primLoad && !auxLoad && !step) |=> $stable(beatQ));
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic clk,
  input  logic rstN,
  input  burstCtrl_t ctrl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic orderSel,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   hiQ;
  logic [BEAT_W-1:0] startQ;
  logic [BEAT_W-1:0] lowNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ    <= '0;
      startQ <= '0;
    end else if (ctrl.load) begin
      hiQ    <= addrIn[ADDR_W-1:BEAT_W];
      startQ <= addrIn[BEAT_W-1:0];
    end
  end

  always_comb lowNext = nextLow(startQ, beatIdx, orderSel);

  assign addrOut = {hiQ, lowNext};

  a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(hiQ));

  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> {hiQ, startQ} == $past(addrIn));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic primLoad,
  input  logic auxLoad,
  input  logic step,
  input  logic orderSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0] beatIdx
);
  burstCtrl_t ctrl;
  logic [BEAT_W-1:0] beat;

  burst_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .primLoad(primLoad), .auxLoad(auxLoad),
    .step(step), .ctrl(ctrl), .beatIdx(beat));

  burst_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .addrIn(addrIn),
    .beatIdx(beat), .orderSel(orderSel), .addrOut(addrOut));

  assign beatIdx = beat;
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 20;
  logic clk = 0, rstN = 0;
  logic [AW-1:0] addrIn = '0;
  logic primLoad = 0, auxLoad = 0, step = 0, orderSel = 1;
  logic [AW-1:0] addrOut;
  logic [1:0] beatIdx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .primLoad(primLoad),
    .auxLoad(auxLoad), .step(step), .orderSel(orderSel),
    .addrOut(addrOut), .beatIdx(beatIdx));

  task automatic chk(string req, logic [AW-1:0] expA, logic [1:0] expB);
    checks++;
    if (addrOut !== expA || beatIdx !== expB) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addrOut, beatIdx, expA, expB);
    end
  endtask

  task automatic cyc(logic p, logic a, logic s, logic [AW-1:0] ad);
    primLoad = p; auxLoad = a; step = s; addrIn = ad;
    @(posedge clk); #1;
    primLoad = 0; auxLoad = 0; step = 0;
  endtask

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] st, int k, logic il);
    logic [1:0] lo;
    lo = il ? (st[1:0] ^ 2'(k)) : 2'(st[1:0] + 2'(k));
    return {st[AW-1:2], lo};
  endfunction

  task automatic t_reset;
    chk("R1", '0, 0);
  endtask

  task automatic t_burst(logic il, logic useAux, logic [AW-1:0] st);
    orderSel = il;
    cyc(!useAux, useAux, 0, st);
    chk("R2", st, 0);
    for (int k = 1; k < 5; k++) begin
      cyc(0, 0, 1, '0);
      chk(il ? "R5" : "R6", expAddr(st, k % 4, il), 2'(k % 4));
      if (addrOut[AW-1:2] !== st[AW-1:2]) begin
        errors++; $display("FAIL R7: upper %h expected %h", addrOut[AW-1:2], st[AW-1:2]);
      end
      checks++;
    end
  endtask

  task automatic t_prio;
    orderSel = 1;
    cyc(1, 0, 0, 20'h12340);
    cyc(0, 0, 1, '0);
    cyc(0, 1, 1, 20'hABCD2);
    chk("R3", 20'hABCD2, 0);
  endtask

  task automatic t_hold;
    orderSel = 0;
    cyc(0, 1, 0, 20'h55551);
    cyc(0, 0, 1, '0);
    cyc(0, 0, 0, 20'hFFFFF);
    chk("R8", 20'h55552, 1);
    cyc(0, 0, 0, '0);
    chk("R8", 20'h55552, 1);
  endtask

  task automatic t_b2b;
    orderSel = 1;
    for (int i = 0; i < 3; i++) begin
      logic [AW-1:0] a = 20'h30000 + 20'(i * 7);
      cyc(i[0], !i[0], 1, a);
      chk("R9", a, 0);
    end
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1;
    for (int s = 0; s < 4; s++) begin
      t_burst(1, s[0], 20'hC8A30 | 20'(s));
      t_burst(0, !s[0], 20'h7F0F0 | 20'(s));
    end
    t_prio();
    t_hold();
    t_b2b();
    cyc(0, 0, 1, '0);
    checks++;
    if (beatIdx !== 2'd1) begin
      errors++; $display("FAIL R4: beat=%0d expected 1", beatIdx);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: timeout expected completion"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule